// File: doc/BRIEF.md
# Bidirectional Event Counter with Pin Clocking and Quadrature Decode

This block is a 16-bit up/down counter that serves as a time base or position counter. It takes its count events from one of three sources, picked by a mode input. The first source is the system clock, which gives one event per cycle. The second is an external clock pin, counted on both its rising and its falling edges. The third is a pair of encoder signals decoded as quadrature. In the two clocked modes, the level on a direction pin sets the counting direction. In quadrature mode, the order of the encoder transitions sets it. A fourth mode freezes the count.

Both pins are asynchronous. Each one passes through a two-flop synchronizer before any edge or phase decision is made. Software can load the count at any time, and a load always wins over a count event in the same cycle. Wrapping past either end of the range raises a sticky flag, one for each direction. A sticky error flag records quadrature jumps in which both encoder signals changed at once. A single clear input drops all three flags.

The quadrature decoder is a four-state machine whose states follow the synchronized encoder pattern {A,B}: PH_00, PH_10, PH_11 and PH_01. Its transitions fall into four kinds:
- A forward step (PH_00→PH_10→PH_11→PH_01→PH_00) emits an up event.
- A backward step (the reverse order) emits a down event.
- A jump to the diagonal state (PH_00↔PH_11, PH_10↔PH_01) emits no event and signals an error.
- Staying in the same state emits nothing.

The machine tracks the pins in every mode. It emits events and errors only in quadrature mode.

Top module: `updn_timer`

## Requirements
- R1: While reset is asserted and immediately after it, the count is 0 and all three flags are 0.
- R2: With mode_i = 2'b00 (internal), the count changes by one on every clock. It counts up when the synchronized direction pin is 1 and down when it is 0.
- R3: With mode_i = 2'b01 (pin clock), every rising edge and every falling edge of tclk_pin_i moves the count by one. The direction pin level picks the direction (1 = up, 0 = down). Without an edge, the count holds.
- R4: A change on either pin affects the count on the third rising clock edge after the change (two synchronizer stages plus the edge/phase stage), and not earlier.
- R5: With mode_i = 2'b10 (quadrature), the encoder pattern is {A = tclk_pin_i, B = tdir_pin_i}. Each single-bit step in the order 00→10→11→01→00 adds one, and each step in the reverse order subtracts one.
- R6: In quadrature mode, a change of both encoder bits between samples leaves the count unchanged and sets the sticky qerr_o. In any other mode, such a change never sets qerr_o.
- R7: A count-up event at 16'hFFFF yields 0 and sets the sticky ovf_o on the same edge.
- R8: A count-down event at 0 yields 16'hFFFF and sets the sticky unf_o on the same edge.
- R9: flag_clr_i clears all three flags on the next edge. A wrap or jump in that same cycle leaves its flag set.
- R10: wr_en_i loads wr_data_i into the count on the next edge. A count event in that cycle is dropped and sets no flag.
- R11: With mode_i = 2'b11 (hold), the count does not change whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 internal, 01 pin clock, 10 quadrature, 11 hold |
| tclk_pin_i | input | 1 | External clock pin, or encoder A in quadrature mode |
| tdir_pin_i | input | 1 | Direction level pin, or encoder B in quadrature mode |
| wr_en_i | input | 1 | Load strobe for the count |
| wr_data_i | input | 16 | Value to load |
| flag_clr_i | input | 1 | Clears the overflow, underflow and quadrature-error flags |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Sticky wrap-up flag |
| unf_o | output | 1 | Sticky wrap-down flag |
| qerr_o | output | 1 | Sticky illegal quadrature-jump flag |

## Verification
Pin activity reaches the count three rising edges after the pin changes. A load, a flag clear and the mode input act on the very next edge, and a wrap flag rises on the same edge as the wrapping count. The bench drives all inputs just after a falling edge and keeps a reference model that advances on each rising edge. The model pushes the pin values through its own three-deep delay line and applies loads and clears at once. Every falling edge compares all four outputs against the model, so an event landing one cycle early or late shows up as a miscompare. Directed sequences isolate a lone pin edge, a load colliding with a count and a clear colliding with a wrap, and random pin traffic covers the rest.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        MODE_INTERNAL = 2'b00,
        MODE_PINCLK   = 2'b01,
        MODE_QUAD     = 2'b10,
        MODE_HOLD     = 2'b11
    } tmr_mode_e;

    // state value equals the synchronized encoder pattern {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } quad_phase_e;

    typedef struct packed {
        logic fire;
        logic up;
    } cnt_evt_t;

endpackage

// File: rtl/timer_insync.sv
module timer_insync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/timer_quad_fsm.sv
module timer_quad_fsm
    import timer_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic [1:0] ab_i,
    output logic       up_o,
    output logic       dn_o,
    output logic       jump_o
);
    quad_phase_e state_q, state_d;
    logic up_raw, dn_raw, jump_raw;

    // state register: always follows the sampled pattern
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PH_00;
        else         state_q <= state_d;
    end

    // transition classification and outputs
    always_comb begin
        state_d  = quad_phase_e'(ab_i);
        up_raw   = 1'b0;
        dn_raw   = 1'b0;
        jump_raw = 1'b0;
        unique case (state_q)
            PH_00: begin
                if      (ab_i == 2'b10) up_raw   = 1'b1;
                else if (ab_i == 2'b01) dn_raw   = 1'b1;
                else if (ab_i == 2'b11) jump_raw = 1'b1;
            end
            PH_10: begin
                if      (ab_i == 2'b11) up_raw   = 1'b1;
                else if (ab_i == 2'b00) dn_raw   = 1'b1;
                else if (ab_i == 2'b01) jump_raw = 1'b1;
            end
            PH_11: begin
                if      (ab_i == 2'b01) up_raw   = 1'b1;
                else if (ab_i == 2'b10) dn_raw   = 1'b1;
                else if (ab_i == 2'b00) jump_raw = 1'b1;
            end
            PH_01: begin
                if      (ab_i == 2'b00) up_raw   = 1'b1;
                else if (ab_i == 2'b11) dn_raw   = 1'b1;
                else if (ab_i == 2'b10) jump_raw = 1'b1;
            end
        endcase
    end

    assign up_o   = en_i & up_raw;
    assign dn_o   = en_i & dn_raw;
    assign jump_o = en_i & jump_raw;
endmodule

// File: rtl/timer_core.sv
module timer_core
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  cnt_evt_t         evt_i,
    input  logic             jump_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             qerr_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic ovf_q, unf_q, qerr_q;
    logic take_evt, wrap_up, wrap_dn;

    always_comb begin
        take_evt = evt_i.fire & ~wr_en_i;
        wrap_up  = take_evt &  evt_i.up & (cnt_q == CNT_MAX);
        wrap_dn  = take_evt & ~evt_i.up & (cnt_q == '0);
        if (wr_en_i)       cnt_d = wr_data_i;
        else if (take_evt) cnt_d = evt_i.up ? cnt_q + CNT_ONE : cnt_q - CNT_ONE;
        else               cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
            qerr_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            ovf_q  <= wrap_up | (ovf_q  & ~clr_i);
            unf_q  <= wrap_dn | (unf_q  & ~clr_i);
            qerr_q <= jump_i  | (qerr_q & ~clr_i);
        end
    end

    assign count_o = cnt_q;
    assign ovf_o   = ovf_q;
    assign unf_o   = unf_q;
    assign qerr_o  = qerr_q;
endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       mode_i,
    input  logic             tclk_pin_i,
    input  logic             tdir_pin_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             qerr_o
);
    localparam int PIN_N = 2;

    tmr_mode_e        mode;
    logic [PIN_N-1:0] pins_s;
    logic             clk_s, dir_s, clk_prev_q;
    logic             q_up, q_dn, q_jump;
    cnt_evt_t         evt;

    assign mode = tmr_mode_e'(mode_i);

    timer_insync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({tclk_pin_i, tdir_pin_i}),
        .sync_o  (pins_s)
    );

    assign clk_s = pins_s[1];
    assign dir_s = pins_s[0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) clk_prev_q <= 1'b0;
        else         clk_prev_q <= clk_s;
    end

    timer_quad_fsm i_quad (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (mode == MODE_QUAD),
        .ab_i   (pins_s),
        .up_o   (q_up),
        .dn_o   (q_dn),
        .jump_o (q_jump)
    );

    // event source select
    always_comb begin
        unique case (mode)
            MODE_INTERNAL: evt = '{fire: 1'b1,               up: dir_s};
            MODE_PINCLK:   evt = '{fire: clk_s ^ clk_prev_q, up: dir_s};
            MODE_QUAD:     evt = '{fire: q_up | q_dn,        up: q_up};
            MODE_HOLD:     evt = '{fire: 1'b0,               up: 1'b0};
        endcase
    end

    timer_core #(.CNT_W(CNT_W)) i_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (evt),
        .jump_i    (q_jump),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .clr_i     (flag_clr_i),
        .count_o   (count_o),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o),
        .qerr_o    (qerr_o)
    );
endmodule

// File: rtl/updn_timer_checker.sv
module updn_timer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       mode_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             unf_o,
    input logic             qerr_o
);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            assert_reset_R1: assert (count_o == '0 && !ovf_o && !unf_o && !qerr_o);
        end
    end

    assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + ONE
                      || count_o == $past(count_o) - ONE));

    assert_qerr_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(qerr_o) |-> $past(mode_i) == 2'b10);

    assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> ($past(count_o) == ALL1 && count_o == '0));

    assert_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(unf_o) |-> ($past(count_o) == '0 && count_o == ALL1));

    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !flag_clr_i) |=> ovf_o);

    assert_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> count_o == $past(wr_data_i));

    assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b11 && !wr_en_i) |=> $stable(count_o));
endmodule

bind updn_timer updn_timer_checker #(.CNT_W(CNT_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .flag_clr_i (flag_clr_i),
    .count_o    (count_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o),
    .qerr_o     (qerr_o)
);

// File: tb/test_updn_timer.sv
module test_updn_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'b11;
    logic         pc = 1'b0, pd = 1'b0, wr = 1'b0, clr = 1'b0;
    logic [W-1:0] wd = '0;
    logic [W-1:0] count;
    logic         ovf, unf, qerr;

    int    n_vec = 0, n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    updn_timer i_updn_timer (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tclk_pin_i(pc), .tdir_pin_i(pd),
        .wr_en_i(wr), .wr_data_i(wd), .flag_clr_i(clr),
        .count_o(count), .ovf_o(ovf), .unf_o(unf), .qerr_o(qerr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model
    logic [1:0]   s1 = 0, s2 = 0, s3 = 0;
    logic [W-1:0] m_cnt = 0;
    logic         m_ovf = 0, m_unf = 0, m_qerr = 0;
    logic [1:0]   ev;
    logic         m_jump;

    function automatic logic [1:0] fwd(input logic [1:0] p);
        case (p)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    // returns {fire, up}
    function automatic logic [1:0] model_evt(input logic [1:0] md, input logic [1:0] now,
                                             input logic [1:0] old);
        case (md)
            2'b00: return {1'b1, now[0]};
            2'b01: return {now[1] ^ old[1], now[0]};
            2'b10: begin
                if (now == old || (now ^ old) == 2'b11) return 2'b00;
                return {1'b1, now == fwd(old)};
            end
            default: return 2'b00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            s1 = 0; s2 = 0; s3 = 0; m_cnt = 0; m_ovf = 0; m_unf = 0; m_qerr = 0;
        end else begin
            ev     = model_evt(mode, s2, s3);
            m_jump = (mode == 2'b10) && ((s2 ^ s3) == 2'b11);
            if (clr) begin m_ovf = 0; m_unf = 0; m_qerr = 0; end
            if (m_jump) m_qerr = 1;
            if (wr) m_cnt = wd;
            else if (ev[1]) begin
                if (ev[0]) begin if (m_cnt == '1) m_ovf = 1; m_cnt = m_cnt + 1'b1; end
                else       begin if (m_cnt == '0) m_unf = 1; m_cnt = m_cnt - 1'b1; end
            end
            s3 = s2; s2 = s1; s1 = {pc, pd};
        end
    end

    task automatic chk(input string rq, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, "count", count, m_cnt);
            chk("R7", "ovf", {15'd0, ovf}, {15'd0, m_ovf});
            chk("R8", "unf", {15'd0, unf}, {15'd0, m_unf});
            chk("R6", "qerr", {15'd0, qerr}, {15'd0, m_qerr});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] q;
        int unsigned r;
        r = $urandom(32'd4242);
        // R1: reset state
        tag = "R1"; cyc(3); rst_n = 1'b1; cyc(1);
        // R2: internal clock, both directions, crosses zero -> R8
        tag = "R2"; mode = 2'b00; pd = 1'b1; cyc(10); pd = 1'b0; cyc(20);
        tag = "R9"; clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
        // R7: wrap upward
        tag = "R7"; pd = 1'b1; wr = 1'b1; wd = 16'hFFF8; cyc(1); wr = 1'b0; cyc(15);
        // R10: load colliding with count events
        tag = "R10"; wr = 1'b1; wd = 16'h1234; cyc(1); wr = 1'b0; cyc(2);
        clr = 1'b1; wr = 1'b1; wd = 16'hFFFF; cyc(1); clr = 1'b0; wr = 1'b0; cyc(3);
        // R9: clear colliding with a wrap, set wins
        tag = "R9"; wr = 1'b1; wd = 16'hFFFF; cyc(1); wr = 1'b0; clr = 1'b1; cyc(1);
        clr = 1'b0; cyc(2); clr = 1'b1; cyc(1); clr = 1'b0;
        // R11: hold mode ignores pins
        tag = "R11"; mode = 2'b11; cyc(3);
        for (int i = 0; i < 60; i++) begin pc = 1'($urandom); pd = 1'($urandom); cyc(1); end
        // R4: lone pin edge latency
        tag = "R4"; pc = 1'b0; pd = 1'b1; cyc(4); mode = 2'b01; cyc(4);
        pc = 1'b1; cyc(1); cyc(1); cyc(1); cyc(2);
        pc = 1'b0; pd = 1'b0; cyc(5);
        // R6: both pins toggling in pin-clock mode never sets qerr
        tag = "R6"; pc = 1'b1; pd = 1'b1; cyc(4); pc = 1'b0; pd = 1'b0; cyc(4);
        // R3: random pin clock traffic
        tag = "R3";
        for (int i = 0; i < 500; i++) begin
            r = $urandom;
            if (r[1:0] != 0) pc = ~pc;
            if (r[4:2] == 0) pd = ~pd;
            clr = (r[9:5] == 0);
            wr  = (r[15:10] == 0);
            wd  = 16'(r >> 16);
            cyc(1);
        end
        clr = 1'b0; wr = 1'b0;
        // R5: quadrature walk with occasional jumps (R6)
        tag = "R5"; q = 2'b00; pc = 1'b0; pd = 1'b0; cyc(4); mode = 2'b10; cyc(2);
        for (int i = 0; i < 600; i++) begin
            r = $urandom % 32;
            if (r < 12)      q = fwd(q);
            else if (r < 22) q = {q[0], ~q[1]};
            else if (r < 30) q = q;
            else             q = ~q;
            clr = ($urandom % 40 == 0);
            {pc, pd} = q;
            cyc(1);
        end
        clr = 1'b0;
        // R5: long forward run across the top of range
        wr = 1'b1; wd = 16'hFFF0; cyc(1); wr = 1'b0;
        for (int i = 0; i < 40; i++) begin q = fwd(q); {pc, pd} = q; cyc(2); end
        mode = 2'b11; cyc(5);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule